// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block resolves a virtual address to a physical address by walking a hierarchy of translation tables held in memory. A request supplies the virtual address, the base address of the first table, the level at which the walk begins and a set of walk parameters: the index stride per level, the output address size, a stage-2 flag, a flag that switches off hierarchical attribute merging, a wide-descriptor mode bit and the security state of the access. The walker then issues one 64-bit descriptor read per level over a simple request/acknowledge memory port. It keeps descending through table entries until it reaches a block or page entry.

At the leaf it returns the physical address, a 22-bit merged attribute vector, a guarded flag and the log2 page size. If a descriptor is invalid, if an address lies outside the configured output size, or if the memory port signals an error, the walk ends with a fault type and the level of the failing read. Permission-related table bits are OR-accumulated on the way down and folded into the leaf attributes. The security space of each fetch follows the accumulated non-secure table bit.

Top module: `ptw_walker`

## Requirements
- R1: The descriptor read address at each level is the current table base ORed with `(va >> stride*(4-level)) & (((1<<stride)-1) << 3)`, with bits [2:0] forced to zero.
- R2: A descriptor with bit 0 clear, or with bit 1 clear at level 3, ends the walk with fault type 1 (translation) and the level of that read.
- R3: A valid descriptor with bit 1 set at levels 0..2 is a table entry. Its bits [63:59] are ORed into a 5-bit table-attribute register, the level increments, and the next read uses the descriptor's address field (bits [47:stride+3]) as the table base. There is exactly one read per level walked.
- R4: The table-attribute register starts with bit 4 equal to 1 for a non-secure request and 0 for a secure one. `mem_ns` always shows bit 4 of the accumulated value during a read.
- R5: When `req_osize` exceeds 48 and wide mode is set, descriptor bits [9:8] become address bits [51:50]. When `req_osize` exceeds 48 in the other mode, descriptor bits [15:12] become address bits [51:48] and address bits [15:12] are cleared. When `req_osize` is 48 or less, any next-address bit at or above `req_osize` gives fault type 2 (address size).
- R6: For a leaf, `res_shift` = stride*(4-level)+3. `res_pa` is the next address with its low `res_shift` bits replaced by those of the virtual address.
- R7: Before merging, `res_attr[9:0]` holds descriptor bits [11:2] and `res_attr[21:10]` holds descriptor bits [63:52].
- R8: For a stage-2 walk no table attributes are merged and `res_guarded` is 0. Otherwise the accumulated bit 4 is ORed into attr bit 3 and `res_guarded` takes descriptor bit 50. With the hierarchy-off flag set, merging stops there.
- R9: With merging fully enabled, accumulated bits [1:0] are ORed into attr bits [12:11], accumulated bit 2 clears attr bit 4 (inverted sense), and accumulated bit 3 is ORed into attr bit 5.
- R10: A memory error on a read ends the walk with fault type 3 (external) and the level of that read. On any fault, `res_pa`, `res_attr`, `res_guarded` and `res_shift` are zero.
- R11: `start` is taken only while `busy` is low, and a `start` during a walk has no effect. `mem_req` holds with a stable address until `mem_ack`. `done` is a one-cycle pulse after which `busy` falls, and the result outputs change only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken when idle) |
| req_va | input | VA_W | Virtual address to translate |
| req_base | input | PA_W | Base address of the first table |
| req_level | input | 2 | Level of the first table (0..3) |
| req_stride | input | 4 | Index bits per level |
| req_osize | input | 6 | Output address size in bits |
| req_stage2 | input | 1 | Stage-2 walk: no table attribute merge |
| req_hier_off | input | 1 | Hierarchical attribute merge disabled |
| req_wide_desc | input | 1 | Selects which descriptor field carries high address bits |
| req_secure | input | 1 | Access is secure |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | PA_W | Descriptor read address |
| mem_ns | output | 1 | Security space of the read (1 = non-secure) |
| mem_ack | input | 1 | Read response valid |
| mem_rdata | input | 64 | Descriptor returned |
| mem_err | input | 1 | Read failed |
| res_pa | output | PA_W | Translated physical address |
| res_attr | output | 22 | Merged attributes |
| res_guarded | output | 1 | Guarded-page flag |
| res_shift | output | 6 | log2 of the page or block size |
| res_fault | output | 3 | 0 none, 1 translation, 2 address size, 3 external |
| res_flevel | output | 2 | Level of the faulting read |

## Verification
The assertions assume the memory side follows the port protocol: `mem_ack` arrives only in a cycle where `mem_req` is high, and `mem_rdata` and `mem_err` are meaningful only in that cycle. They also assume `req_stride` and `req_level` describe a walk whose shifts stay inside 64 bits. The bench responder raises `mem_ack` for a single cycle, only in answer to a pending request. Every request uses stride 9 or 13 with output sizes of 40, 48 or 52, and the table chains are built so that every base is aligned to its granule.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int DESC_W = 64;
    localparam int ATTR_W = 22;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_XLAT  = 3'd1,
        FLT_ASIZE = 3'd2,
        FLT_EXT   = 3'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } walk_state_e;
endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
    parameter int VA_W = 64,
    parameter int PA_W = 52
) (
    input  logic [VA_W-1:0] va,
    input  logic [PA_W-1:0] base,
    input  logic [1:0]      level,
    input  logic [3:0]      stride,
    output logic [PA_W-1:0] addr
);
    localparam int W = ptw_pkg::DESC_W;

    logic [5:0]   levels_left;
    logic [5:0]   shamt;
    logic [W-1:0] idx_mask;
    logic [W-1:0] idx;

    always_comb begin
        levels_left = 6'd4 - {4'd0, level};
        shamt       = 6'(stride) * levels_left;
        idx_mask    = ((W'(1) << stride) - W'(1)) << 3;
        idx         = (W'(va) >> shamt) & idx_mask;
        addr        = (base | idx[PA_W-1:0]) & ~PA_W'(7);
    end
endmodule

// File: rtl/ptw_decode.sv
module ptw_decode #(
    parameter int NARROW_OA = 48
) (
    input  logic [63:0] desc,
    input  logic [1:0]  level,
    input  logic [3:0]  stride,
    input  logic [5:0]  osize,
    input  logic        wide,
    output logic        invalid,
    output logic        is_table,
    output logic        size_fault,
    output logic [63:0] next
);
    localparam int W = ptw_pkg::DESC_W;
    localparam logic [W-1:0] TOP_MASK = (W'(1) << NARROW_OA) - W'(1);

    logic [5:0] gran_bits;

    always_comb begin
        gran_bits  = {2'b00, stride} + 6'd3;
        next       = desc & TOP_MASK & ~((W'(1) << gran_bits) - W'(1));
        size_fault = 1'b0;
        if (osize > 6'(NARROW_OA)) begin
            if (wide) begin
                next[51:50] = desc[9:8];
            end else begin
                next[15:12] = 4'd0;
                next[51:48] = desc[15:12];
            end
        end else begin
            size_fault = (next >> osize) != '0;
        end
        invalid  = !desc[0] || (!desc[1] && level == 2'd3);
        is_table = desc[1] && level != 2'd3;
    end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf #(
    parameter int VA_W = 64
) (
    input  logic [63:0]               next,
    input  logic [VA_W-1:0]           va,
    input  logic [1:0]                level,
    input  logic [3:0]                stride,
    input  logic [4:0]                tattr,
    input  logic                      stage2,
    input  logic                      hier_off,
    input  logic [11:0]               desc_hi,
    input  logic [9:0]                desc_lo,
    input  logic                      desc_gp,
    output logic [63:0]               pa,
    output logic [ptw_pkg::ATTR_W-1:0] attr,
    output logic                      guarded,
    output logic [5:0]                shift
);
    localparam int W = ptw_pkg::DESC_W;

    logic [W-1:0] pmask;

    always_comb begin
        shift   = 6'(stride) * (6'd4 - {4'd0, level}) + 6'd3;
        pmask   = (W'(1) << shift) - W'(1);
        pa      = (next & ~pmask) | (W'(va) & pmask);
        attr    = {desc_hi, desc_lo};
        guarded = 1'b0;
        if (!stage2) begin
            attr[3] = attr[3] | tattr[4];
            guarded = desc_gp;
            if (!hier_off) begin
                attr[12:11] = attr[12:11] | tattr[1:0];
                attr[4]     = attr[4] & ~tattr[2];
                attr[5]     = attr[5] | tattr[3];
            end
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int VA_W      = 64,
    parameter int PA_W      = 52,
    parameter int NARROW_OA = 48
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [VA_W-1:0]            req_va,
    input  logic [PA_W-1:0]            req_base,
    input  logic [1:0]                 req_level,
    input  logic [3:0]                 req_stride,
    input  logic [5:0]                 req_osize,
    input  logic                       req_stage2,
    input  logic                       req_hier_off,
    input  logic                       req_wide_desc,
    input  logic                       req_secure,
    output logic                       busy,
    output logic                       done,
    output logic                       mem_req,
    output logic [PA_W-1:0]            mem_addr,
    output logic                       mem_ns,
    input  logic                       mem_ack,
    input  logic [63:0]                mem_rdata,
    input  logic                       mem_err,
    output logic [PA_W-1:0]            res_pa,
    output logic [ptw_pkg::ATTR_W-1:0] res_attr,
    output logic                       res_guarded,
    output logic [5:0]                 res_shift,
    output logic [2:0]                 res_fault,
    output logic [1:0]                 res_flevel
);
    import ptw_pkg::*;

    typedef struct packed {
        walk_state_e       state;
        logic [VA_W-1:0]   va;
        logic [PA_W-1:0]   base;
        logic [1:0]        level;
        logic [3:0]        stride;
        logic [5:0]        osize;
        logic              stage2;
        logic              hier_off;
        logic              wide;
        logic [4:0]        tattr;
        logic [PA_W-1:0]   pa;
        logic [ATTR_W-1:0] attr;
        logic              guarded;
        logic [5:0]        shift;
        fault_e            fault;
        logic [1:0]        flevel;
    } walk_t;

    walk_t walk_d, walk_q;

    logic              dec_invalid, dec_table, dec_size;
    logic [63:0]       dec_next, leaf_pa;
    logic [ATTR_W-1:0] leaf_attr;
    logic              leaf_gp;
    logic [5:0]        leaf_shift;

    ptw_index #(.VA_W(VA_W), .PA_W(PA_W)) u_index (
        .va(walk_q.va), .base(walk_q.base), .level(walk_q.level),
        .stride(walk_q.stride), .addr(mem_addr)
    );

    ptw_decode #(.NARROW_OA(NARROW_OA)) u_decode (
        .desc(mem_rdata), .level(walk_q.level), .stride(walk_q.stride),
        .osize(walk_q.osize), .wide(walk_q.wide), .invalid(dec_invalid),
        .is_table(dec_table), .size_fault(dec_size), .next(dec_next)
    );

    ptw_leaf #(.VA_W(VA_W)) u_leaf (
        .next(dec_next), .va(walk_q.va), .level(walk_q.level),
        .stride(walk_q.stride), .tattr(walk_q.tattr), .stage2(walk_q.stage2),
        .hier_off(walk_q.hier_off), .desc_hi(mem_rdata[63:52]),
        .desc_lo(mem_rdata[11:2]), .desc_gp(mem_rdata[50]), .pa(leaf_pa),
        .attr(leaf_attr), .guarded(leaf_gp), .shift(leaf_shift)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (start) begin
                    walk_d.state    = ST_FETCH;
                    walk_d.va       = req_va;
                    walk_d.base     = req_base;
                    walk_d.level    = req_level;
                    walk_d.stride   = req_stride;
                    walk_d.osize    = req_osize;
                    walk_d.stage2   = req_stage2;
                    walk_d.hier_off = req_hier_off;
                    walk_d.wide     = req_wide_desc;
                    walk_d.tattr    = {~req_secure, 4'b0000};
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    if (!mem_err && !dec_invalid && !dec_size && dec_table) begin
                        walk_d.tattr = walk_q.tattr | mem_rdata[63:59];
                        walk_d.level = walk_q.level + 2'd1;
                        walk_d.base  = dec_next[PA_W-1:0];
                    end else begin
                        walk_d.state   = ST_DONE;
                        walk_d.flevel  = walk_q.level;
                        walk_d.pa      = '0;
                        walk_d.attr    = '0;
                        walk_d.guarded = 1'b0;
                        walk_d.shift   = '0;
                        if (mem_err) begin
                            walk_d.fault = FLT_EXT;
                        end else if (dec_invalid) begin
                            walk_d.fault = FLT_XLAT;
                        end else if (dec_size) begin
                            walk_d.fault = FLT_ASIZE;
                        end else begin
                            walk_d.fault   = FLT_NONE;
                            walk_d.pa      = leaf_pa[PA_W-1:0];
                            walk_d.attr    = leaf_attr;
                            walk_d.guarded = leaf_gp;
                            walk_d.shift   = leaf_shift;
                        end
                    end
                end
            end
            default: walk_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign busy        = walk_q.state != ST_IDLE;
    assign done        = walk_q.state == ST_DONE;
    assign mem_req     = walk_q.state == ST_FETCH;
    assign mem_ns      = walk_q.tattr[4];
    assign res_pa      = walk_q.pa;
    assign res_attr    = walk_q.attr;
    assign res_guarded = walk_q.guarded;
    assign res_shift   = walk_q.shift;
    assign res_fault   = walk_q.fault;
    assign res_flevel  = walk_q.flevel;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int PA_W = 52
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_ns,
    input logic            mem_ack,
    input logic            mem_err,
    input logic            rd_bit0,
    input logic [PA_W-1:0] res_pa,
    input logic [2:0]      res_fault
);
    assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[2:0] == 3'd0);

    assert_invalid_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !mem_err && !rd_bit0 |=> done && res_fault == 3'd1);

    assert_ext_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_err |=> done && res_fault == 3'd3);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_ns));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    assert_start_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy && mem_req);

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(res_pa) && $stable(res_fault));
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ns(mem_ns), .mem_ack(mem_ack),
    .mem_err(mem_err), .rd_bit0(mem_rdata[0]), .res_pa(res_pa),
    .res_fault(res_fault)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
    localparam int VA_W = 64;
    localparam int PA_W = 52;
    localparam logic [63:0] PA_MASK = (64'd1 << PA_W) - 64'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic start = 1'b0;
    logic [VA_W-1:0] req_va = '0;
    logic [PA_W-1:0] req_base = '0;
    logic [1:0] req_level = '0;
    logic [3:0] req_stride = 4'd9;
    logic [5:0] req_osize = 6'd48;
    logic req_stage2 = 0, req_hier_off = 0, req_wide_desc = 0, req_secure = 0;
    logic busy, done, mem_req, mem_ns, mem_ack, mem_err, res_guarded;
    logic [PA_W-1:0] mem_addr, res_pa;
    logic [63:0] mem_rdata;
    logic [21:0] res_attr;
    logic [5:0] res_shift;
    logic [2:0] res_fault;
    logic [1:0] res_flevel;

    ptw_walker #(.VA_W(VA_W), .PA_W(PA_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_va(req_va),
        .req_base(req_base), .req_level(req_level), .req_stride(req_stride),
        .req_osize(req_osize), .req_stage2(req_stage2), .req_hier_off(req_hier_off),
        .req_wide_desc(req_wide_desc), .req_secure(req_secure), .busy(busy),
        .done(done), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ns(mem_ns),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .res_pa(res_pa), .res_attr(res_attr), .res_guarded(res_guarded),
        .res_shift(res_shift), .res_fault(res_fault), .res_flevel(res_flevel)
    );

    logic [63:0] mem [logic [63:0]];
    bit          errmap [logic [63:0]];

    typedef struct {
        logic [63:0] pa;
        logic [21:0] attr;
        logic        guarded;
        int          shift;
        int          fault;
        int          flevel;
        int          nreads;
        logic [63:0] last_addr;
        logic        last_ns;
    } exp_t;

    exp_t  sbq[$];
    string tagq[$];
    int n_cmp = 0, n_bad = 0;
    int reads_seen = 0;
    logic [63:0] last_addr_seen = '0;
    logic last_ns_seen = 1'b0;

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [63:0] tdesc(logic [63:0] nx, logic [4:0] ta);
        return {ta, 59'd0} | (nx & 64'h0000_FFFF_FFFF_F000) | 64'h3;
    endfunction

    // Reference walk, written from the requirements
    function automatic exp_t ref_walk(logic [63:0] va, logic [63:0] base, int lvl,
                                      int stride, int osize, bit s2, bit hoff,
                                      bit wide, bit sec);
        exp_t e;
        logic [63:0] da, d, nx, pm;
        logic [4:0] t;
        int sh;
        e = '{pa: 0, attr: 0, guarded: 0, shift: 0, fault: 0, flevel: 0,
              nreads: 0, last_addr: 0, last_ns: 0};
        t  = {~sec, 4'b0};
        da = base;
        for (int i = 0; i < 5; i++) begin
            da = (da | ((va >> (stride * (4 - lvl))) & (((64'd1 << stride) - 1) << 3))) & ~64'h7;
            e.nreads++;
            e.last_addr = da;
            e.last_ns   = t[4];
            if (errmap.exists(da)) begin e.fault = 3; e.flevel = lvl; return e; end
            d = mem.exists(da) ? mem[da] : 64'd0;
            if (!d[0] || (!d[1] && lvl == 3)) begin e.fault = 1; e.flevel = lvl; return e; end
            nx = d & ((64'd1 << 48) - 1) & ~((64'd1 << (stride + 3)) - 1);
            if (osize > 48) begin
                if (wide) nx[51:50] = d[9:8];
                else begin nx[15:12] = 4'd0; nx[51:48] = d[15:12]; end
            end else if ((nx >> osize) != 0) begin
                e.fault = 2; e.flevel = lvl; return e;
            end
            if (d[1] && lvl < 3) begin
                t = t | d[63:59];
                lvl++;
                da = nx;
                continue;
            end
            sh = stride * (4 - lvl) + 3;
            pm = (64'd1 << sh) - 1;
            e.pa     = ((nx & ~pm) | (va & pm)) & PA_MASK;
            e.shift  = sh;
            e.flevel = lvl;
            e.attr   = {d[63:52], d[11:2]};
            if (!s2) begin
                e.attr[3] = e.attr[3] | t[4];
                e.guarded = d[50];
                if (!hoff) begin
                    e.attr[12:11] = e.attr[12:11] | t[1:0];
                    if (t[2]) e.attr[4] = 1'b0;
                    e.attr[5] = e.attr[5] | t[3];
                end
            end
            return e;
        end
        return e;
    endfunction

    // Memory responder: one-cycle ack per pending request
    initial begin
        mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                logic [63:0] a;
                a = 64'(mem_addr);
                reads_seen++;
                last_addr_seen = a;
                last_ns_seen   = mem_ns;
                mem_ack   = 1'b1;
                mem_err   = errmap.exists(a);
                mem_rdata = mem.exists(a) ? mem[a] : 64'd0;
            end else begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end
        end
    end

    // Monitor: pop and compare at each done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sbq.size() == 0) begin
                    check("R11", "unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    string tg;
                    e  = sbq.pop_front();
                    tg = tagq.pop_front();
                    check(tg, "res_pa", 64'(res_pa), e.pa);
                    check(tg, "res_attr", 64'(res_attr), 64'(e.attr));
                    check(tg, "res_guarded", 64'(res_guarded), 64'(e.guarded));
                    check(tg, "res_shift", 64'(res_shift), 64'(e.shift));
                    check(tg, "res_fault", 64'(res_fault), 64'(e.fault));
                    if (e.fault != 0) check(tg, "res_flevel", 64'(res_flevel), 64'(e.flevel));
                    check("R3", "read count", 64'(reads_seen), 64'(e.nreads));
                    check("R1", "last descriptor addr", last_addr_seen, e.last_addr);
                    check("R4", "last mem_ns", 64'(last_ns_seen), 64'(e.last_ns));
                end
            end
        end
    end

    task automatic walk(string tag, logic [63:0] va, logic [63:0] base, int lvl,
                        int stride, int osize, bit s2, bit hoff, bit wide, bit sec,
                        bit poke);
        exp_t e;
        e = ref_walk(va, base, lvl, stride, osize, s2, hoff, wide, sec);
        sbq.push_back(e);
        tagq.push_back(tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_va = va; req_base = base[PA_W-1:0]; req_level = 2'(lvl);
        req_stride = 4'(stride); req_osize = 6'(osize); req_stage2 = s2;
        req_hier_off = hoff; req_wide_desc = wide; req_secure = sec;
        reads_seen = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: a start while busy must be ignored
            @(negedge clk);
            req_va = ~va; req_base = '0; req_level = 2'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    localparam logic [63:0] VA1 = 64'h0000_0080_8060_4123;

    initial begin
        // 4K tables for a 4-level chain
        mem[64'h10008] = tdesc(64'h20000, 5'b00001);
        mem[64'h20010] = tdesc(64'h30000, 5'b00100);
        mem[64'h30018] = tdesc(64'h40000, 5'b01000);
        mem[64'h40020] = 64'hF010_0000_ABCD_E7D7;
        mem[64'h30028] = 64'h0004_0000_4020_0401;
        mem[64'h40030] = 64'h0000_0000_5555_5001;
        mem[64'h40038] = 64'h0000_1000_0000_0003;
        mem[64'h40040] = 64'h0000_0000_1234_5303;
        mem[64'h40048] = 64'h0000_0000_1234_A003;
        errmap[64'h30020] = 1'b1;
        // 64K granule chain (stride 13)
        mem[64'h800008] = tdesc(64'h900000, 5'b10010);
        mem[64'h900018] = 64'h0000_0000_0AB0_0E13;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11", "busy after reset", 64'(busy), 64'd0);
        check("R11", "done after reset", 64'(done), 64'd0);
        check("R11", "mem_req after reset", 64'(mem_req), 64'd0);
        check("R10", "res_fault after reset", 64'(res_fault), 64'd0);

        walk("R9",  VA1, 64'h10000, 0, 9, 48, 0, 0, 0, 0, 0);
        walk("R7",  VA1, 64'h10000, 0, 9, 48, 1, 0, 0, 0, 0);
        walk("R8",  VA1, 64'h10000, 0, 9, 48, 0, 1, 0, 0, 0);
        walk("R4",  VA1, 64'h10000, 0, 9, 48, 0, 0, 0, 1, 0);
        walk("R6",  64'h0000_0000_80A1_2345, 64'h20000, 1, 9, 48, 0, 0, 0, 1, 0);
        walk("R3",  VA1, 64'h30000, 2, 9, 48, 0, 0, 0, 0, 0);
        walk("R2",  64'h0000_0100_8060_4123, 64'h10000, 0, 9, 48, 0, 0, 0, 0, 0);
        walk("R2",  64'h0000_0080_8060_6123, 64'h10000, 0, 9, 48, 0, 0, 0, 0, 0);
        walk("R5",  64'h0000_0080_8060_7123, 64'h10000, 0, 9, 40, 0, 0, 0, 0, 0);
        walk("R5",  64'h0000_0080_8060_7123, 64'h10000, 0, 9, 48, 0, 0, 0, 0, 0);
        walk("R5",  64'h0000_0080_8060_8123, 64'h10000, 0, 9, 52, 0, 0, 1, 0, 0);
        walk("R5",  64'h0000_0080_8060_9123, 64'h10000, 0, 9, 52, 0, 0, 0, 0, 0);
        walk("R10", 64'h0000_0080_8080_4123, 64'h10000, 0, 9, 48, 0, 0, 0, 0, 0);
        walk("R6",  64'h0000_0000_2003_ABCD, 64'h800000, 2, 13, 48, 0, 0, 0, 0, 0);
        walk("R11", VA1, 64'h10000, 0, 9, 48, 0, 0, 0, 0, 1);

        // R11: results hold while idle
        repeat (3) @(negedge clk);
        check("R11", "busy while idle", 64'(busy), 64'd0);
        check("R11", "res_pa held", 64'(res_pa), ref_walk(VA1, 64'h10000, 0, 9, 48, 0, 0, 0, 0).pa);
        check("R11", "scoreboard drained", 64'(sbq.size()), 64'd0);
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule